// File: doc/BRIEF.md
# Sequential Logic Output Cell

This block is one output cell of a programmable logic device that holds state. It takes a bundle of product terms built by an AND array elsewhere, masks off the terms that are not in use, ORs the rest into a single sum and can complement that sum. The result is either latched in a flip-flop or sent straight out. It then goes to a bidirectional pin, and one selected signal goes back to the array as feedback.

Every option is held on static configuration inputs, so one cell can serve as a registered output, a combinational output or a pure input. The options are the sum polarity, registered or combinational output, the active clock edge, asynchronous preset and clear, the pin direction and the feedback source. The flip-flop also has a synchronous active-high reset that returns it to 0.

Top module: `pld_macrocell`

## Requirements
- R1: With all terms enabled and inversion off, the sum is 1 exactly when at least one of the `NUM_PT` (default 8) product terms is 1.
- R2: A product term whose bit in `cfg_pt_en_i` is 0 has no effect on the sum, whatever its value.
- R3: When `cfg_invert_i` is 1, the value sent to the flip-flop and to the combinational path is the complement of the sum.
- R4: When `cfg_bypass_i` is 1, the pin carries the combinational value at once. When it is 0, the pin carries the flip-flop output.
- R5: With `cfg_fall_edge_i` = 0 the flip-flop loads on the rising clock edge. With `cfg_fall_edge_i` = 1 it loads on the falling edge and ignores the rising edge.
- R6: The flip-flop is forced to 0 at once while `clr_i` and `cfg_clr_en_i` are both 1. It is forced to 1 at once while `set_i` and `cfg_set_en_i` are both 1. Clear takes priority over preset. A request whose enable is 0 has no effect.
- R7: A synchronous reset (`rst` = 1) returns the flip-flop to 0 at the next active clock edge.
- R8: With `cfg_oe_i` = 1 the cell drives the pin. With `cfg_oe_i` = 0 the cell releases the pin, so an external driver sets its level.
- R9: `cfg_fb_sel_i` picks the feedback: 0 gives the flip-flop output, 1 gives the complemented-or-plain sum, and 2 or 3 give the pin level. With `cfg_oe_i` = 0 the feedback is the pin level, whatever the selection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the flip-flop |
| rst | input | 1 | Synchronous active-high reset of the flip-flop |
| pterm_i | input | NUM_PT | Product terms from the AND array |
| cfg_pt_en_i | input | NUM_PT | Per-term enable mask |
| cfg_invert_i | input | 1 | Complement the sum |
| cfg_bypass_i | input | 1 | 1: combinational output, 0: registered output |
| cfg_fall_edge_i | input | 1 | 1: load on the falling edge, 0: load on the rising edge |
| cfg_set_en_i | input | 1 | Allow the asynchronous preset |
| cfg_clr_en_i | input | 1 | Allow the asynchronous clear |
| cfg_oe_i | input | 1 | 1: the pin is an output, 0: the pin is an input |
| cfg_fb_sel_i | input | 2 | Feedback source select |
| set_i | input | 1 | Asynchronous preset request |
| clr_i | input | 1 | Asynchronous clear request |
| io_pin | inout | 1 | Bidirectional device pin |
| fb_o | output | 1 | Feedback to the AND array |

## Verification
The sum is tried with each term alone, with no term, with several terms at once, and with masks that hide the only active term. Together these separate a true OR from an AND or a single-bit tap, and show whether the mask really gates each term. The registered path is sampled before the falling edge, after it, and after the following rising edge, which tells the two clock edges apart. A separate point with the flip-flop and the sum holding different values separates the bypass and feedback choices. The asynchronous tests assert preset and clear between clock edges, singly and together, and with their enables off, so an immediate response, the priority between them and the gating can each be seen.

// File: rtl/mc_pkg.sv
package mc_pkg;

    typedef enum logic [1:0] {
        FB_REG  = 2'd0,
        FB_SUM  = 2'd1,
        FB_PIN  = 2'd2,
        FB_PIN2 = 2'd3
    } fb_sel_e;

    typedef struct packed {
        logic    invert;
        logic    bypass;
        logic    fall_edge;
        logic    set_en;
        logic    clr_en;
        logic    oe;
        fb_sel_e fb_sel;
    } mc_cfg_t;

    // Feedback choice; an input-mode pin always returns its own level
    function automatic logic pick_fb(input fb_sel_e sel, input logic oe,
                                     input logic q, input logic s, input logic pin);
        logic r;
        if (!oe) begin
            r = pin;
        end else begin
            case (sel)
                FB_REG:  r = q;
                FB_SUM:  r = s;
                default: r = pin;
            endcase
        end
        return r;
    endfunction

endpackage

// File: rtl/mc_sum_term.sv
module mc_sum_term #(
    parameter int NUM_PT = 8
) (
    input  logic [NUM_PT-1:0] terms_i,
    input  logic [NUM_PT-1:0] en_i,
    input  logic              invert_i,
    output logic              sum_o
);
    logic [NUM_PT-1:0] gated;

    for (genvar i = 0; i < NUM_PT; i++) begin : g_gate
        assign gated[i] = terms_i[i] & en_i[i];
    end

    // Polarity stage: a single XOR after the wide OR
    assign sum_o = (|gated) ^ invert_i;

endmodule

// File: rtl/mc_flop.sv
module mc_flop (
    input  logic clk,
    input  logic rst,
    input  logic fall_edge_i,
    input  logic set_en_i,
    input  logic clr_en_i,
    input  logic set_i,
    input  logic clr_i,
    input  logic d_i,
    output logic q_o
);
    logic a_set;
    logic a_clr;
    logic q_rise;
    logic q_fall;

    assign a_set = set_i & set_en_i;
    assign a_clr = clr_i & clr_en_i;

    always_ff @(posedge clk or posedge a_clr or posedge a_set) begin
        if (a_clr)      q_rise <= 1'b0;
        else if (a_set) q_rise <= 1'b1;
        else if (rst)   q_rise <= 1'b0;
        else            q_rise <= d_i;
    end

    always_ff @(negedge clk or posedge a_clr or posedge a_set) begin
        if (a_clr)      q_fall <= 1'b0;
        else if (a_set) q_fall <= 1'b1;
        else if (rst)   q_fall <= 1'b0;
        else            q_fall <= d_i;
    end

    assign q_o = fall_edge_i ? q_fall : q_rise;

    // R6: clear dominates whenever it is requested and allowed
    p_clear_wins_r6: assert property (@(posedge clk) disable iff (rst)
        (clr_i && clr_en_i) |-> (q_o == 1'b0));

    // R6: an allowed preset without a clear holds the output high
    p_preset_r6: assert property (@(posedge clk) disable iff (rst)
        (set_i && set_en_i && !(clr_i && clr_en_i)) |-> (q_o == 1'b1));

    // R5: rising-edge mode loads the data seen at the previous rising edge
    p_rise_load_r5: assert property (@(posedge clk) disable iff (rst)
        (!fall_edge_i && $past(!fall_edge_i) && $past(!rst)
         && !a_set && !a_clr && $past(!a_set) && $past(!a_clr))
        |-> (q_o == $past(d_i)));

    // R5: falling-edge mode loads the data seen at the previous falling edge
    p_fall_load_r5: assert property (@(negedge clk) disable iff (rst)
        (fall_edge_i && $past(fall_edge_i) && $past(!rst)
         && !a_set && !a_clr && $past(!a_set) && $past(!a_clr))
        |-> (q_o == $past(d_i)));

endmodule

// File: rtl/mc_route.sv
module mc_route
    import mc_pkg::*;
(
    input  mc_cfg_t cfg_i,
    input  logic    q_i,
    input  logic    sum_i,
    input  logic    pin_i,
    output logic    drive_val_o,
    output logic    drive_en_o,
    output logic    fb_o
);
    assign drive_val_o = cfg_i.bypass ? sum_i : q_i;
    assign drive_en_o  = cfg_i.oe;
    assign fb_o        = pick_fb(cfg_i.fb_sel, cfg_i.oe, q_i, sum_i, pin_i);
endmodule

// File: rtl/pld_macrocell.sv
module pld_macrocell
    import mc_pkg::*;
#(
    parameter int NUM_PT = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_PT-1:0] pterm_i,
    input  logic [NUM_PT-1:0] cfg_pt_en_i,
    input  logic              cfg_invert_i,
    input  logic              cfg_bypass_i,
    input  logic              cfg_fall_edge_i,
    input  logic              cfg_set_en_i,
    input  logic              cfg_clr_en_i,
    input  logic              cfg_oe_i,
    input  logic [1:0]        cfg_fb_sel_i,
    input  logic              set_i,
    input  logic              clr_i,
    inout  wire               io_pin,
    output logic              fb_o
);
    mc_cfg_t cfg;
    logic    sum;
    logic    q;
    logic    drive_val;
    logic    drive_en;

    always_comb begin
        cfg.invert    = cfg_invert_i;
        cfg.bypass    = cfg_bypass_i;
        cfg.fall_edge = cfg_fall_edge_i;
        cfg.set_en    = cfg_set_en_i;
        cfg.clr_en    = cfg_clr_en_i;
        cfg.oe        = cfg_oe_i;
        cfg.fb_sel    = fb_sel_e'(cfg_fb_sel_i);
    end

    mc_sum_term #(.NUM_PT(NUM_PT)) u_sum (
        .terms_i  (pterm_i),
        .en_i     (cfg_pt_en_i),
        .invert_i (cfg.invert),
        .sum_o    (sum)
    );

    mc_flop u_flop (
        .clk         (clk),
        .rst         (rst),
        .fall_edge_i (cfg.fall_edge),
        .set_en_i    (cfg.set_en),
        .clr_en_i    (cfg.clr_en),
        .set_i       (set_i),
        .clr_i       (clr_i),
        .d_i         (sum),
        .q_o         (q)
    );

    mc_route u_route (
        .cfg_i       (cfg),
        .q_i         (q),
        .sum_i       (sum),
        .pin_i       (io_pin),
        .drive_val_o (drive_val),
        .drive_en_o  (drive_en),
        .fb_o        (fb_o)
    );

    assign io_pin = drive_en ? drive_val : 1'bz;

    // R2: with no enabled active term the sum reduces to the polarity bit
    p_mask_r2: assert property (@(posedge clk) disable iff (rst)
        ((pterm_i & cfg_pt_en_i) == '0) |-> (sum == cfg_invert_i));

    // R4: a bypassed output pin follows the sum
    p_bypass_r4: assert property (@(posedge clk) disable iff (rst)
        (cfg_oe_i && cfg_bypass_i) |-> (io_pin == sum));

    // R9: sum feedback in output mode returns the sum
    p_fb_sum_r9: assert property (@(posedge clk) disable iff (rst)
        (cfg_oe_i && cfg_fb_sel_i == 2'd1) |-> (fb_o == sum));

endmodule

// File: tb/sim_pld_macrocell.sv
module sim_pld_macrocell;
    localparam int NPT = 8;

    logic           clk = 1'b0;
    logic           rst;
    logic [NPT-1:0] pt;
    logic [NPT-1:0] en;
    logic           inv, byp, fall, set_en, clr_en, oe;
    logic [1:0]     fbs;
    logic           set_r, clr_r;
    logic           tb_drv_en, tb_drv_val;
    wire            io_pin;
    logic           fb;

    int checks = 0;
    int errors = 0;

    assign io_pin = tb_drv_en ? tb_drv_val : 1'bz;

    always #5 clk = ~clk;

    pld_macrocell #(.NUM_PT(NPT)) u0 (
        .clk(clk), .rst(rst), .pterm_i(pt), .cfg_pt_en_i(en),
        .cfg_invert_i(inv), .cfg_bypass_i(byp), .cfg_fall_edge_i(fall),
        .cfg_set_en_i(set_en), .cfg_clr_en_i(clr_en), .cfg_oe_i(oe),
        .cfg_fb_sel_i(fbs), .set_i(set_r), .clr_i(clr_r),
        .io_pin(io_pin), .fb_o(fb)
    );

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    // Rising edge at 10k+5; this returns 2 ns later
    task automatic after_rise();
        @(posedge clk);
        #2;
    endtask

    task automatic t_reset();
        rst = 1'b1; pt = '0; en = '1; inv = 0; byp = 0; fall = 0;
        set_en = 0; clr_en = 0; oe = 1; fbs = 2'd0; set_r = 0; clr_r = 0;
        tb_drv_en = 0; tb_drv_val = 0;
        pt = '1;
        after_rise(); after_rise();
        check("R7 reset", io_pin, 1'b0);
        rst = 1'b0;
    endtask

    task automatic t_or();
        byp = 1; pt = '0; #1;
        check("R1 no term", io_pin, 1'b0);
        for (int i = 0; i < NPT; i++) begin
            pt = '0; pt[i] = 1'b1; #1;
            check("R1 single term", io_pin, 1'b1);
        end
        pt = 8'b1010_0101; #1;
        check("R1 several terms", io_pin, 1'b1);
    endtask

    task automatic t_mask();
        pt = 8'b0000_1000; en = 8'b1111_0111; #1;
        check("R2 masked only term", io_pin, 1'b0);
        pt = 8'b1111_1111; en = 8'b0000_0000; #1;
        check("R2 all masked", io_pin, 1'b0);
        pt = 8'b0100_1000; en = 8'b1111_0111; #1;
        check("R2 other term enabled", io_pin, 1'b1);
        en = '1;
    endtask

    task automatic t_invert();
        inv = 1; pt = '0; #1;
        check("R3 inverted zero", io_pin, 1'b1);
        pt = 8'b0001_0000; #1;
        check("R3 inverted one", io_pin, 1'b0);
        inv = 0;
    endtask

    task automatic t_edges();
        byp = 0; fall = 0; pt = '0;
        after_rise(); after_rise();
        check("R5 rise start", io_pin, 1'b0);
        pt = 8'h01;
        #2; check("R5 rise before edge", io_pin, 1'b0);
        #3; check("R5 rise ignores fall edge", io_pin, 1'b0);
        #5; check("R5 rise loads", io_pin, 1'b1);
        // both flops now hold 1; choose falling edge and drive 0
        #2; fall = 1; pt = '0;
        #1; check("R5 fall before edge", io_pin, 1'b1);
        #3; check("R5 fall loads", io_pin, 1'b0);
        // R4: bypass toggles between sum and register with no edge
        pt = 8'h02;
        #1; check("R4 registered holds", io_pin, 1'b0);
        byp = 1; #1; check("R4 bypass shows sum", io_pin, 1'b1);
        byp = 0; #1; check("R4 back to register", io_pin, 1'b0);
        fall = 0;
    endtask

    task automatic t_async();
        pt = 8'h01; after_rise(); after_rise();
        check("R6 setup high", io_pin, 1'b1);
        clr_en = 1; clr_r = 1; #1;
        check("R6 clear immediate", io_pin, 1'b0);
        after_rise();
        check("R6 clear held over edge", io_pin, 1'b0);
        clr_r = 0; after_rise();
        check("R6 reload after clear", io_pin, 1'b1);
        pt = '0; after_rise();
        check("R6 low before preset", io_pin, 1'b0);
        set_en = 1; set_r = 1; #1;
        check("R6 preset immediate", io_pin, 1'b1);
        clr_r = 1; #1;
        check("R6 clear beats preset", io_pin, 1'b0);
        after_rise();
        check("R6 clear beats preset at edge", io_pin, 1'b0);
        clr_r = 0; set_r = 0; after_rise();
        set_en = 0; set_r = 1; #1;
        check("R6 disabled preset ignored", io_pin, 1'b0);
        after_rise();
        set_r = 0; pt = 8'h01; after_rise();
        clr_en = 0; clr_r = 1; #1;
        check("R6 disabled clear ignored", io_pin, 1'b1);
        clr_r = 0;
    endtask

    task automatic t_sync_reset();
        pt = 8'h01; after_rise();
        rst = 1; #1;
        check("R7 reset waits for edge", io_pin, 1'b1);
        after_rise();
        check("R7 reset at edge", io_pin, 1'b0);
        rst = 0;
    endtask

    task automatic t_feedback();
        // register 0, sum 1
        pt = '0; after_rise(); pt = 8'h80; #1;
        fbs = 2'd0; #1; check("R9 fb register", fb, 1'b0);
        fbs = 2'd1; #1; check("R9 fb sum", fb, 1'b1);
        fbs = 2'd2; #1; check("R9 fb pin output mode", fb, 1'b0);
        // R8: release the pin, external level wins
        oe = 0; tb_drv_en = 1; tb_drv_val = 1; #1;
        check("R8 released pin takes external 1", io_pin, 1'b1);
        fbs = 2'd0; #1; check("R9 input mode forces pin", fb, 1'b1);
        tb_drv_val = 0; byp = 1; #1;
        check("R8 released pin takes external 0", io_pin, 1'b0);
        fbs = 2'd1; #1; check("R9 input mode ignores sum", fb, 1'b0);
        tb_drv_en = 0; oe = 1; #1;
        check("R8 driving again", io_pin, 1'b1);
    endtask

    initial begin
        t_reset();
        t_or();
        t_mask();
        t_invert();
        t_edges();
        t_async();
        t_sync_reset();
        t_feedback();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #100000;
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule